// File: doc/BRIEF.md
# Cascaded Two-Lane 8b/10b Code-Group Decoder

This block turns received 10-bit line code groups back into bytes. Each byte comes with a flag that marks it as a control character. The block also tracks running disparity across the stream. For every code group it reports whether the group was legal but arrived with the wrong running disparity, or whether it is not a legal code group at all. The mapping is the standard 8b/10b code used on Ethernet-class serial links.

Two decoder lanes sit side by side. In single-width mode, lane 0 takes one code group per clock and lane 1 is idle. In double-width mode, both lanes take a 20-bit word that carries two consecutive code groups. Lane 1 starts from the disparity that lane 0 has just produced in the same cycle, so the pair behaves like one decoder running at twice the rate. The running disparity left by the last active lane is registered and carried into the next clock.

Top module: `cgdec_cascade`

## Requirements
- R1: Code group bits are taken as `code_in[9:0]` = {a,b,c,d,e,i,f,g,h,j}, where a is the first bit on the line. A legal data group decodes to `data_out[7:0]` = {H,G,F,E,D,C,B,A}, which is Dx.y with x = byte[4:0] and y = byte[7:5]. Its control flag is 0.
- R2: The twelve control groups K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7 decode to their byte value (for example K28.5 = 8'hBC) with the control flag set to 1.
- R3: Running disparity is negative (0) after reset. Each lane's `rd_out` bit is the disparity after its code group, with 1 meaning positive.
- R4: A group that is legal only in the opposite running-disparity column sets that lane's disparity-error flag and leaves its code-error flag at 0.
- R5: A 10-bit pattern that is in neither disparity column sets the code-error flag and leaves the disparity-error flag at 0.
- R6: The disparity after every group, erroneous or not, is rebuilt from the received bits. After the 6-bit sub-block it is positive when that sub-block has more ones than zeros or equals 000111, and negative when it has fewer ones or equals 111000; otherwise it is unchanged. After the 4-bit sub-block it is positive when that sub-block has more ones or equals 0011, and negative when it has fewer ones or equals 1100; otherwise it is unchanged. A single disparity error therefore does not flag the groups that follow.
- R7: With `dbl_mode` = 0 only lane 0 decodes. `code_in[19:10]` has no effect, every lane-1 output bit is 0, and lane 0 takes its disparity from its own previous group.
- R8: With `dbl_mode` = 1, `code_in[9:0]` is the earlier group and is decoded into the low byte and bit 0 of each status output. `code_in[19:10]` is decoded in the same cycle, starting from lane 0's resulting disparity. Lane 1's disparity is carried into the next cycle.
- R9: All outputs are registered with one clock of latency, and reset clears every output to 0.
- R10: `dbl_mode` changes only while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbl_mode | input | 1 | 0 = one group per clock, 1 = two cascaded groups per clock |
| code_in | input | 20 | Received code groups; lane 0 in bits 9:0, lane 1 in bits 19:10 |
| data_out | output | 16 | Decoded bytes; lane 0 in bits 7:0 |
| ctrl_out | output | 2 | Control-character flag per lane |
| disp_err_out | output | 2 | Disparity-error flag per lane |
| code_err_out | output | 2 | Invalid-code flag per lane |
| rd_out | output | 2 | Running disparity after each lane's group (1 = positive) |

## Verification
The decoder is driven with streams of properly encoded random bytes and control characters. These show that both disparity columns and the alternate x.7 forms decode correctly as the running disparity swings. Into those streams go three kinds of error: groups encoded against the wrong disparity, which must give disparity errors and not code errors; single flipped bits; and fully random patterns, which separate the two error kinds and exercise the rebuild rule for disparity. Directed pairs in double-width mode put a K28.5 of each polarity side by side, a pair that is only legal when lane 1 sees lane 0's disparity. Single-width runs put garbage on the upper half to show that it is ignored.

// File: rtl/cgdec_pkg.sv
package cgdec_pkg;

    localparam int CG_W   = 10;
    localparam int BYTE_W = 8;

    // 6-bit sub-block for Dx in the negative-disparity column, bit 5 = a
    function automatic logic [5:0] six_base(input logic [4:0] x);
        logic [5:0] c;
        case (x)
            5'd0:  c = 6'b100111;  5'd1:  c = 6'b011101;
            5'd2:  c = 6'b101101;  5'd3:  c = 6'b110001;
            5'd4:  c = 6'b110101;  5'd5:  c = 6'b101001;
            5'd6:  c = 6'b011001;  5'd7:  c = 6'b111000;
            5'd8:  c = 6'b111001;  5'd9:  c = 6'b100101;
            5'd10: c = 6'b010101;  5'd11: c = 6'b110100;
            5'd12: c = 6'b001101;  5'd13: c = 6'b101100;
            5'd14: c = 6'b011100;  5'd15: c = 6'b010111;
            5'd16: c = 6'b011011;  5'd17: c = 6'b100011;
            5'd18: c = 6'b010011;  5'd19: c = 6'b110010;
            5'd20: c = 6'b001011;  5'd21: c = 6'b101010;
            5'd22: c = 6'b011010;  5'd23: c = 6'b111010;
            5'd24: c = 6'b110011;  5'd25: c = 6'b100110;
            5'd26: c = 6'b010110;  5'd27: c = 6'b110110;
            5'd28: c = 6'b001110;  5'd29: c = 6'b101110;
            5'd30: c = 6'b011110;  default: c = 6'b101011;
        endcase
        return c;
    endfunction

    // 4-bit sub-block for Dx.y in the negative-disparity column, bit 3 = f
    function automatic logic [3:0] four_base(input logic [2:0] y);
        logic [3:0] c;
        case (y)
            3'd0: c = 4'b1011;  3'd1: c = 4'b1001;
            3'd2: c = 4'b0101;  3'd3: c = 4'b1100;
            3'd4: c = 4'b1101;  3'd5: c = 4'b1010;
            3'd6: c = 4'b0110;  default: c = 4'b1110;
        endcase
        return c;
    endfunction

    function automatic logic two6(input logic [5:0] c);
        return ($countones(c) != 3) || (c == 6'b111000);
    endfunction

    function automatic logic two4(input logic [3:0] c);
        return ($countones(c) != 2) || (c == 4'b1100);
    endfunction

    function automatic logic rd6(input logic [5:0] c, input logic rd);
        logic r;
        r = rd;
        if ($countones(c) > 3 || c == 6'b000111) r = 1'b1;
        else if ($countones(c) < 3 || c == 6'b111000) r = 1'b0;
        return r;
    endfunction

    function automatic logic rd4(input logic [3:0] c, input logic rd);
        logic r;
        r = rd;
        if ($countones(c) > 2 || c == 4'b0011) r = 1'b1;
        else if ($countones(c) < 2 || c == 4'b1100) r = 1'b0;
        return r;
    endfunction

    function automatic logic k7_x(input logic [4:0] x);
        return (x == 5'd23) || (x == 5'd27) || (x == 5'd29) || (x == 5'd30);
    endfunction

    // returns {legal, code group} for byte b, control flag k, disparity rd
    function automatic logic [CG_W:0] encode_cg(input logic [7:0] b, input logic k, input logic rd);
        logic [4:0] x;
        logic [2:0] y;
        logic [5:0] c6;
        logic [3:0] c4;
        logic       rdm, ok, alt;
        x  = b[4:0];
        y  = b[7:5];
        ok = !k || (x == 5'd28) || (y == 3'd7 && k7_x(x));
        c6 = (k && x == 5'd28) ? 6'b001111 : six_base(x);
        if (rd && two6(c6)) c6 = ~c6;
        rdm = rd6(c6, rd);
        if (k && x == 5'd28) begin
            c4 = (y == 3'd7) ? 4'b1000
               : (two4(four_base(y)) ? ~four_base(y) : four_base(y));
            if (!rdm) c4 = ~c4;
        end else begin
            alt = (y == 3'd7) && (k
                  || (!rdm && (x == 5'd17 || x == 5'd18 || x == 5'd20))
                  || ( rdm && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
            if (alt) c4 = rdm ? 4'b1000 : 4'b0111;
            else begin
                c4 = four_base(y);
                if (rdm && two4(c4)) c4 = ~c4;
            end
        end
        return {ok, c6, c4};
    endfunction

endpackage

// File: rtl/cgdec_lane.sv
module cgdec_lane
    import cgdec_pkg::*;
(
    input  logic [CG_W-1:0]   code_i,
    input  logic              rd_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              ctrl_o,
    output logic              derr_o,
    output logic              cerr_o,
    output logic              rd_o
);
    logic [5:0]    c6;
    logic [3:0]    c4, c4e;
    logic [4:0]    x;
    logic [2:0]    y;
    logic          f6, f4, k28, a7, k;
    logic [CG_W:0] e_cur, e_oth;
    logic          m_cur, m_oth;

    assign c6 = code_i[9:4];
    assign c4 = code_i[3:0];

    always_comb begin
        k28 = (c6 == 6'b001111) || (c6 == 6'b110000);
        f6  = k28;
        x   = 5'd28;
        for (int i = 0; i < 32; i++) begin
            if (!f6 && (c6 == six_base(5'(i)) ||
                        (two6(six_base(5'(i))) && c6 == ~six_base(5'(i))))) begin
                f6 = 1'b1;
                x  = 5'(i);
            end
        end
        c4e = (c6 == 6'b110000) ? ~c4 : c4;
        a7  = (c4e == 4'b0111) || (c4e == 4'b1000);
        f4  = a7;
        y   = 3'd7;
        for (int j = 0; j < 8; j++) begin
            if (!f4 && (c4e == four_base(3'(j)) ||
                        (two4(four_base(3'(j))) && c4e == ~four_base(3'(j))))) begin
                f4 = 1'b1;
                y  = 3'(j);
            end
        end
        k     = k28 || (a7 && k7_x(x));
        e_cur = encode_cg({y, x}, k, rd_i);
        e_oth = encode_cg({y, x}, k, !rd_i);
        m_cur = f6 && f4 && e_cur[CG_W] && (e_cur[CG_W-1:0] == code_i);
        m_oth = f6 && f4 && e_oth[CG_W] && (e_oth[CG_W-1:0] == code_i);
    end

    assign byte_o = {y, x};
    assign ctrl_o = k;
    assign derr_o = !m_cur && m_oth;
    assign cerr_o = !m_cur && !m_oth;
    assign rd_o   = rd4(c4, rd6(c6, rd_i));

endmodule

// File: rtl/cgdec_cascade.sv
module cgdec_cascade
    import cgdec_pkg::*;
#(
    parameter int NUM_LANES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          dbl_mode,
    input  logic [NUM_LANES*CG_W-1:0]     code_in,
    output logic [NUM_LANES*BYTE_W-1:0]   data_out,
    output logic [NUM_LANES-1:0]          ctrl_out,
    output logic [NUM_LANES-1:0]          disp_err_out,
    output logic [NUM_LANES-1:0]          code_err_out,
    output logic [NUM_LANES-1:0]          rd_out
);
    localparam int LAST = NUM_LANES - 1;

    typedef struct packed {
        logic [NUM_LANES*BYTE_W-1:0] data;
        logic [NUM_LANES-1:0]        ctrl;
        logic [NUM_LANES-1:0]        derr;
        logic [NUM_LANES-1:0]        cerr;
        logic [NUM_LANES-1:0]        rd;
        logic                        rd_carry;
    } st_t;

    st_t st_d, st_q;

    logic [BYTE_W-1:0] l_byte [NUM_LANES];
    logic              l_ctrl [NUM_LANES];
    logic              l_derr [NUM_LANES];
    logic              l_cerr [NUM_LANES];
    logic              l_rdi  [NUM_LANES];
    logic              l_rdo  [NUM_LANES];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        if (g == 0) begin : g_first
            assign l_rdi[g] = st_q.rd_carry;
        end else begin : g_chain
            assign l_rdi[g] = l_rdo[g-1];
        end
        cgdec_lane u_lane (
            .code_i (code_in[g*CG_W +: CG_W]),
            .rd_i   (l_rdi[g]),
            .byte_o (l_byte[g]),
            .ctrl_o (l_ctrl[g]),
            .derr_o (l_derr[g]),
            .cerr_o (l_cerr[g]),
            .rd_o   (l_rdo[g])
        );
    end

    always_comb begin
        st_d = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (i == 0 || dbl_mode) begin
                st_d.data[i*BYTE_W +: BYTE_W] = l_byte[i];
                st_d.ctrl[i] = l_ctrl[i];
                st_d.derr[i] = l_derr[i];
                st_d.cerr[i] = l_cerr[i];
                st_d.rd[i]   = l_rdo[i];
            end
        end
        st_d.rd_carry = dbl_mode ? l_rdo[LAST] : l_rdo[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_out     = st_q.data;
    assign ctrl_out     = st_q.ctrl;
    assign disp_err_out = st_q.derr;
    assign code_err_out = st_q.cerr;
    assign rd_out       = st_q.rd;

endmodule

// File: rtl/cgdec_cascade_chk.sv
module cgdec_cascade_chk
    import cgdec_pkg::*;
#(
    parameter int NUM_LANES = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        dbl_mode,
    input logic [NUM_LANES*BYTE_W-1:0] data_out,
    input logic [NUM_LANES-1:0]        ctrl_out,
    input logic [NUM_LANES-1:0]        disp_err_out,
    input logic [NUM_LANES-1:0]        code_err_out,
    input logic [NUM_LANES-1:0]        rd_out
);
    // R10
    mode_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && $past(rst_n) |-> $stable(dbl_mode));

    // R7
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dbl_mode) |-> (data_out[NUM_LANES*BYTE_W-1:BYTE_W] == '0 &&
                              ctrl_out[NUM_LANES-1:1] == '0 &&
                              disp_err_out[NUM_LANES-1:1] == '0 &&
                              code_err_out[NUM_LANES-1:1] == '0 &&
                              rd_out[NUM_LANES-1:1] == '0));

    // R4
    err_kind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(disp_err_out[0] && code_err_out[0]));

    // R2
    ctrl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_out[0] && !code_err_out[0]) |->
        (data_out[4:0] == 5'd28 || (data_out[7:5] == 3'd7 && k7_x(data_out[4:0]))));

    // R5
    err_upper_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(disp_err_out[NUM_LANES-1] && code_err_out[NUM_LANES-1]));

endmodule

bind cgdec_cascade cgdec_cascade_chk #(.NUM_LANES(NUM_LANES)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .dbl_mode     (dbl_mode),
    .data_out     (data_out),
    .ctrl_out     (ctrl_out),
    .disp_err_out (disp_err_out),
    .code_err_out (code_err_out),
    .rd_out       (rd_out)
);

// File: tb/cgdec_cascade_tb_top.sv
module cgdec_cascade_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbl_mode = 1'b0;
    logic [19:0] code_in = '0;
    logic [15:0] data_out;
    logic [1:0]  ctrl_out, disp_err_out, code_err_out, rd_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic m_rd = 1'b0;

    always #2 clk = ~clk;

    cgdec_cascade dut_i (
        .clk(clk), .rst_n(rst_n), .dbl_mode(dbl_mode), .code_in(code_in),
        .data_out(data_out), .ctrl_out(ctrl_out), .disp_err_out(disp_err_out),
        .code_err_out(code_err_out), .rd_out(rd_out)
    );

    localparam logic [7:0] KLIST [12] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC,
                                          8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE};

    // 6-bit sub-block, both columns: {neg, pos}
    function automatic logic [11:0] t6(input logic [4:0] x, input logic k);
        if (k) return {6'b001111, 6'b110000};
        case (x)
            0: return {6'b100111, 6'b011000};  1: return {6'b011101, 6'b100010};
            2: return {6'b101101, 6'b010010};  3: return {2{6'b110001}};
            4: return {6'b110101, 6'b001010};  5: return {2{6'b101001}};
            6: return {2{6'b011001}};          7: return {6'b111000, 6'b000111};
            8: return {6'b111001, 6'b000110};  9: return {2{6'b100101}};
            10: return {2{6'b010101}};         11: return {2{6'b110100}};
            12: return {2{6'b001101}};         13: return {2{6'b101100}};
            14: return {2{6'b011100}};         15: return {6'b010111, 6'b101000};
            16: return {6'b011011, 6'b100100}; 17: return {2{6'b100011}};
            18: return {2{6'b010011}};         19: return {2{6'b110010}};
            20: return {2{6'b001011}};         21: return {2{6'b101010}};
            22: return {2{6'b011010}};         23: return {6'b111010, 6'b000101};
            24: return {6'b110011, 6'b001100}; 25: return {2{6'b100110}};
            26: return {2{6'b010110}};         27: return {6'b110110, 6'b001001};
            28: return {2{6'b001110}};         29: return {6'b101110, 6'b010001};
            30: return {6'b011110, 6'b100001}; default: return {6'b101011, 6'b010100};
        endcase
    endfunction

    // 4-bit sub-block data columns: {neg, pos}
    function automatic logic [7:0] t4(input logic [2:0] y);
        case (y)
            0: return {4'b1011, 4'b0100}; 1: return {2{4'b1001}};
            2: return {2{4'b0101}};       3: return {4'b1100, 4'b0011};
            4: return {4'b1101, 4'b0010}; 5: return {2{4'b1010}};
            6: return {2{4'b0110}};       default: return {4'b1110, 4'b0001};
        endcase
    endfunction

    function automatic logic nrd(input logic [9:0] c, input logic rd);
        logic r;
        r = rd;
        if ($countones(c[9:4]) > 3 || c[9:4] == 6'b000111) r = 1;
        else if ($countones(c[9:4]) < 3 || c[9:4] == 6'b111000) r = 0;
        if ($countones(c[3:0]) > 2 || c[3:0] == 4'b0011) r = 1;
        else if ($countones(c[3:0]) < 2 || c[3:0] == 4'b1100) r = 0;
        return r;
    endfunction

    function automatic logic [9:0] tenc(input logic [7:0] b, input logic k, input logic rd);
        logic [11:0] s6;
        logic [5:0]  c6;
        logic [3:0]  c4;
        logic        rm;
        logic [4:0]  x;
        x  = b[4:0];
        s6 = t6(x, k && x == 28);
        c6 = rd ? s6[5:0] : s6[11:6];
        rm = nrd({c6, 4'b0101}, rd);
        if (k && x == 28) begin
            c4 = (b[7:5] == 7) ? 4'b1000 : t4(b[7:5])[3:0];
            if (!rm) c4 = ~c4;
        end else if (b[7:5] == 7 && (k || (!rm && (x == 17 || x == 18 || x == 20))
                                      || (rm && (x == 11 || x == 13 || x == 14))))
            c4 = rm ? 4'b1000 : 4'b0111;
        else
            c4 = rm ? t4(b[7:5])[3:0] : t4(b[7:5])[7:4];
        return {c6, c4};
    endfunction

    // {kind(0 ok,1 disp,2 code), k, byte}
    function automatic logic [10:0] classify(input logic [9:0] c, input logic rd);
        logic [10:0] r;
        r = {2'd2, 9'd0};
        for (int b = 0; b < 256; b++) begin
            if (tenc(8'(b), 1'b0, rd) == c) r = {2'd0, 1'b0, 8'(b)};
            else if (r[10:9] == 2'd2 && tenc(8'(b), 1'b0, !rd) == c) r = {2'd1, 1'b0, 8'(b)};
        end
        for (int i = 0; i < 12; i++) begin
            if (tenc(KLIST[i], 1'b1, rd) == c) r = {2'd0, 1'b1, KLIST[i]};
            else if (r[10:9] == 2'd2 && tenc(KLIST[i], 1'b1, !rd) == c) r = {2'd1, 1'b1, KLIST[i]};
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 0; dbl_mode = mode; code_in = '0;
        repeat (2) @(negedge clk);
        // R9 outputs cleared in reset
        chk("R9 reset", {data_out, ctrl_out, disp_err_out, code_err_out, rd_out}, 32'd0);
        rst_n = 1; m_rd = 0;
    endtask

    function automatic logic [12:0] lane_exp(input logic [10:0] cl, input logic rdn);
        // {derr, cerr, rd, ctrl, data} with data/ctrl zeroed on code error
        case (cl[10:9])
            2'd0: return {2'b00, rdn, cl[8:0]};
            2'd1: return {2'b10, rdn, 9'd0};
            default: return {2'b01, rdn, 9'd0};
        endcase
    endfunction

    function automatic string tag(input logic [10:0] cl);
        case (cl[10:9])
            2'd0: return cl[8] ? "R2 ctrl" : "R1 data";
            2'd1: return "R4 disp";
            default: return "R5 code";
        endcase
    endfunction

    task automatic step(input logic [19:0] c, input string extra);
        logic [10:0] c0, c1;
        logic        r0, r1;
        logic [12:0] e0, e1, a0, a1;
        c0 = classify(c[9:0], m_rd);
        r0 = nrd(c[9:0], m_rd);
        c1 = classify(c[19:10], r0);
        r1 = nrd(c[19:10], r0);
        @(negedge clk);
        code_in = c;
        @(negedge clk);
        e0 = lane_exp(c0, r0);
        a0 = {disp_err_out[0], code_err_out[0], rd_out[0],
              (c0[10:9] == 0) ? {ctrl_out[0], data_out[7:0]} : 9'd0};
        chk({tag(c0), " lane0 R3 R6 ", extra}, 32'(a0), 32'(e0));
        if (dbl_mode) begin
            e1 = lane_exp(c1, r1);
            a1 = {disp_err_out[1], code_err_out[1], rd_out[1],
                  (c1[10:9] == 0) ? {ctrl_out[1], data_out[15:8]} : 9'd0};
            chk({tag(c1), " lane1 R8 ", extra}, 32'(a1), 32'(e1));
            m_rd = r1;
        end else begin
            chk({"R7 idle lane ", extra},
                {data_out[15:8], ctrl_out[1], disp_err_out[1], code_err_out[1], rd_out[1]}, 32'd0);
            m_rd = r0;
        end
    endtask

    function automatic logic [9:0] rnd_cg(input logic rd);
        int r;
        logic [7:0] b;
        logic k;
        r = $urandom % 16;
        k = ($urandom % 8) == 0;
        b = k ? KLIST[$urandom % 12] : 8'($urandom);
        if (r == 0) return 10'($urandom);
        if (r == 1) return tenc(b, k, rd) ^ (10'd1 << ($urandom % 10));
        if (r == 2) return tenc(b, k, !rd);
        return tenc(b, k, rd);
    endfunction

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog R9 actual=hung expected=done");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset(1'b0);
        // R3: negative start accepts K28.5 from the negative column
        step({10'h3FF, 10'b001111_1010}, "K28.5- after reset");
        // R4: same group again while disparity is positive
        step({10'h155, 10'b001111_1010}, "repeat K28.5-");
        // R6: recovery, positive-column K28.5 accepted
        step({10'h000, 10'b110000_0101}, "K28.5+ after error");
        // R5: all-zero pattern
        step({10'h2AA, 10'b0000000000}, "all zero");
        // R1: alternate x.7 forms
        step({10'h000, tenc(8'hF1, 1'b0, m_rd)}, "D17.7");
        step({10'h3FF, tenc(8'hEB, 1'b0, m_rd)}, "D11.7");
        for (int i = 0; i < 500; i++) step({10'($urandom), rnd_cg(m_rd)}, "random single");

        do_reset(1'b1);
        // R8: K28.5- then K28.5+ is only legal with cascaded disparity
        step({10'b110000_0101, 10'b001111_1010}, "K28.5 pair");
        step({10'b001111_1010, 10'b001111_1010}, "pair second half wrong");
        for (int i = 0; i < 500; i++) begin
            logic [9:0] lo;
            lo = rnd_cg(m_rd);
            step({rnd_cg(nrd(lo, m_rd)), lo}, "random double");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule